// File: doc/BRIEF.md
# Shared-Resource Multi-Cycle Processor Datapath

This block is the datapath of a 32-bit processor that completes each instruction in several short clock steps rather than one long one. One arithmetic unit serves every purpose: it increments the program counter, forms branch targets, computes load and store addresses and executes register-to-register operations. One memory port carries both instruction fetches and data accesses. Because the hardware is reused from step to step, each intermediate value is held in a dedicated register from one cycle to the next: the instruction register, two operand latches, an ALU result latch and a memory data latch.

The block decides nothing by itself. An external sequencer drives every select and enable on every cycle. It receives back the opcode field of the held instruction and the live zero flag of the ALU, and from these it chooses the next step. Memory sits outside the block and answers a read combinationally within the same cycle. The sequencer drives the memory read and write strobes directly.

Top module: `mc_datapath`

## Requirements
- R1: The memory address equals the program counter when `ctl_addr_alu` is 0 and the ALU result latch when it is 1. Instruction and data accesses share this single port.
- R2: The instruction register loads `mem_rdata` at a clock edge only when `ctl_ir_we` is 1 and otherwise holds its value. `opcode` always shows instruction bits 31:26.
- R3: On every clock edge, operand latch A loads the register addressed by instruction bits 25:21 and operand latch B loads the register addressed by bits 20:16. `mem_wdata` always shows operand latch B.
- R4: The first ALU operand is the program counter when `ctl_opa_reg` is 0 and latch A when it is 1. The second operand, chosen by `ctl_opb_sel`, is latch B (00), the constant 4 (01), instruction bits 15:0 sign-extended (10), or that sign-extended value shifted left by two (11).
- R5: `ctl_alu_mode` 00 adds and 01 subtracts. Mode 10 takes the operation from instruction bits 5:0: 0x20 add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR, 0x2A signed set-less-than (result 1 or 0). Any other code in that field adds.
- R6: `alu_zero` is 1 exactly when the live ALU result in the current cycle is zero.
- R7: The next program counter, chosen by `ctl_pc_src`, is the live ALU result (00), the ALU result latch (01), or the jump target (10). The jump target is program counter bits 31:28 followed by instruction bits 25:0 and two zero bits.
- R8: The program counter resets to 0. It updates when `ctl_pc_we` is 1, or when `ctl_pc_we_zero` is 1 and `alu_zero` is 1. In every other case it holds.
- R9: When `ctl_rf_we` is 1, the register file writes to instruction bits 15:11 (if `ctl_dst_rd` is 1) or bits 20:16 (if it is 0). The data written is the memory data latch (if `ctl_wb_mdr` is 1) or the ALU result latch (if it is 0). Register 0 always reads as zero and ignores writes.
- R10: The memory data latch captures `mem_rdata` at every clock edge, so data returned during a cycle can be written back in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Shared memory address |
| mem_wdata | output | 32 | Store data (operand latch B) |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| ctl_addr_alu | input | 1 | Address select: 0 program counter, 1 ALU result latch |
| ctl_ir_we | input | 1 | Instruction register load enable |
| ctl_pc_we | input | 1 | Unconditional program counter update |
| ctl_pc_we_zero | input | 1 | Program counter update qualified by the zero flag |
| ctl_opa_reg | input | 1 | First operand: 0 program counter, 1 latch A |
| ctl_opb_sel | input | 2 | Second operand select |
| ctl_alu_mode | input | 2 | ALU mode: add, subtract, or function field |
| ctl_pc_src | input | 2 | Next program counter source |
| ctl_dst_rd | input | 1 | Write address: 0 bits 20:16, 1 bits 15:11 |
| ctl_wb_mdr | input | 1 | Write data: 0 ALU latch, 1 memory data latch |
| ctl_rf_we | input | 1 | Register file write enable |
| opcode | output | 6 | Instruction bits 31:26 |
| alu_zero | output | 1 | Live ALU result equals zero |

## Verification
Assertions check the following every cycle: the instruction register holds while its load enable is low; the program counter holds unless one of its enables qualifies it; a plain increment step adds exactly four; a jump keeps the upper four bits of the program counter and yields a word-aligned target; and a register write is visible at the written address on the following cycle. The bench drives full instruction sequences in the role of the sequencer, and only these show the end-to-end behaviour. That covers each function code of the ALU (an unknown code included), taken and not-taken branches, negative offsets on addresses, and register 0 keeping zero after a write to it. It also covers loaded data travelling through the memory data latch into a register and back out as store data.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [2:0] {
      FN_ADD,
      FN_SUB,
      FN_AND,
      FN_OR,
      FN_SLT
   } alu_fn_e;

   // ALU mode encodings from the sequencer
   localparam logic [1:0] MODE_ADD   = 2'b00;
   localparam logic [1:0] MODE_SUB   = 2'b01;
   localparam logic [1:0] MODE_FIELD = 2'b10;

   // function field codes
   localparam logic [5:0] FC_ADD = 6'h20;
   localparam logic [5:0] FC_SUB = 6'h22;
   localparam logic [5:0] FC_AND = 6'h24;
   localparam logic [5:0] FC_OR  = 6'h25;
   localparam logic [5:0] FC_SLT = 6'h2A;

   // second operand selects
   localparam logic [1:0] OPB_REG  = 2'b00;
   localparam logic [1:0] OPB_FOUR = 2'b01;
   localparam logic [1:0] OPB_IMM  = 2'b10;
   localparam logic [1:0] OPB_IMM4 = 2'b11;

   // next program counter sources
   localparam logic [1:0] NPC_LIVE  = 2'b00;
   localparam logic [1:0] NPC_LATCH = 2'b01;
   localparam logic [1:0] NPC_JUMP  = 2'b10;

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   rd_addr_a,
   input  logic [AW-1:0]   rd_addr_b,
   output logic [XLEN-1:0] rd_data_a,
   output logic [XLEN-1:0] rd_data_b,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [XLEN-1:0] wr_data
);

   logic [XLEN-1:0] regs [NREGS];

   if (NREGS != (1 << AW)) begin : g_bad_depth
      $error("mcd_regfile: NREGS must be a power of two");
   end

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_store
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == AW'(g))
               q <= wr_data;
         end
         assign regs[g] = q;
      end
   end

   assign rd_data_a = regs[rd_addr_a];
   assign rd_data_b = regs[rd_addr_b];

   // R9: a write to a nonzero address is visible there on the next cycle
   p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0) |=> regs[$past(wr_addr)] == $past(wr_data));

   // R9: register 0 stays zero after any write aimed at it
   p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> rd_addr_a != '0 || rd_data_a == '0);

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [1:0]      mode,
   input  logic [5:0]      func_field,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] result,
   output logic            zero
);

   alu_fn_e fn;

   always_comb begin
      unique case (mode)
         MODE_SUB:   fn = FN_SUB;
         MODE_FIELD: begin
            case (func_field)
               FC_SUB:  fn = FN_SUB;
               FC_AND:  fn = FN_AND;
               FC_OR:   fn = FN_OR;
               FC_SLT:  fn = FN_SLT;
               default: fn = FN_ADD;
            endcase
         end
         default:    fn = FN_ADD;
      endcase
   end

   always_comb begin
      case (fn)
         FN_SUB:  result = opa - opb;
         FN_AND:  result = opa & opb;
         FN_OR:   result = opa | opb;
         FN_SLT:  result = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
         default: result = opa + opb;
      endcase
   end

   assign zero = (result == '0);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mcd_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREGS    = 32,
   parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   input  logic            ctl_addr_alu,
   input  logic            ctl_ir_we,
   input  logic            ctl_pc_we,
   input  logic            ctl_pc_we_zero,
   input  logic            ctl_opa_reg,
   input  logic [1:0]      ctl_opb_sel,
   input  logic [1:0]      ctl_alu_mode,
   input  logic [1:0]      ctl_pc_src,
   input  logic            ctl_dst_rd,
   input  logic            ctl_wb_mdr,
   input  logic            ctl_rf_we,
   output logic [5:0]      opcode,
   output logic            alu_zero
);

   localparam int AW      = $clog2(NREGS);
   localparam int IMM_W   = 16;
   localparam int JIDX_W  = 26;
   localparam int PC_HI_W = XLEN - JIDX_W - 2;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_datapath: XLEN must be 32 to match the instruction fields");
   end
   if (NREGS > 32 || NREGS < 2) begin : g_bad_nregs
      $error("mc_datapath: NREGS must lie in 2..32");
   end

   logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
   logic [XLEN-1:0] rf_a, rf_b, opa, opb, alu_y, pc_nxt;
   logic [XLEN-1:0] imm_sx, imm_sh, jmp_tgt, wr_data;
   logic [AW-1:0]   wr_addr;
   logic            pc_en;

   // immediate and jump target shaping
   assign imm_sx  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign imm_sh  = imm_sx << 2;
   assign jmp_tgt = {pc_q[XLEN-1 -: PC_HI_W], ir_q[JIDX_W-1:0], 2'b00};

   // operand selection
   assign opa = ctl_opa_reg ? a_q : pc_q;

   always_comb begin
      unique case (ctl_opb_sel)
         OPB_REG:  opb = b_q;
         OPB_FOUR: opb = XLEN'(4);
         OPB_IMM:  opb = imm_sx;
         default:  opb = imm_sh;
      endcase
   end

   mcd_alu #(.XLEN(XLEN)) u_alu (
      .mode       (ctl_alu_mode),
      .func_field (ir_q[5:0]),
      .opa        (opa),
      .opb        (opb),
      .result     (alu_y),
      .zero       (alu_zero)
   );

   // next program counter
   always_comb begin
      case (ctl_pc_src)
         NPC_LATCH: pc_nxt = alu_q;
         NPC_JUMP:  pc_nxt = jmp_tgt;
         default:   pc_nxt = alu_y;
      endcase
   end

   assign pc_en = ctl_pc_we | (ctl_pc_we_zero & alu_zero);

   // register file write-back
   assign wr_addr = ctl_dst_rd ? ir_q[11 +: AW] : ir_q[16 +: AW];
   assign wr_data = ctl_wb_mdr ? mdr_q : alu_q;

   mcd_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr_a (ir_q[21 +: AW]),
      .rd_addr_b (ir_q[16 +: AW]),
      .rd_data_a (rf_a),
      .rd_data_b (rf_b),
      .wr_en     (ctl_rf_we),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   // holding registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= XLEN'(RESET_PC);
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ctl_ir_we) ir_q <= mem_rdata;
         if (pc_en)     pc_q <= pc_nxt;
         mdr_q <= mem_rdata;
         a_q   <= rf_a;
         b_q   <= rf_b;
         alu_q <= alu_y;
      end
   end

   assign mem_addr  = ctl_addr_alu ? alu_q : pc_q;
   assign mem_wdata = b_q;
   assign opcode    = ir_q[31:26];

   // R2: instruction register holds without its load enable
   p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_ir_we |=> $stable(ir_q));

   // R8: program counter holds when neither enable qualifies
   p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_pc_we && !(ctl_pc_we_zero && alu_zero)) |=> $stable(pc_q));

   // R7: an increment step through the live ALU result adds four
   p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_pc_we && ctl_pc_src == NPC_LIVE && !ctl_opa_reg &&
       ctl_opb_sel == OPB_FOUR && ctl_alu_mode == MODE_ADD)
      |=> pc_q == $past(pc_q) + XLEN'(4));

   // R7: a jump keeps the top bits and lands word aligned
   p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_pc_we && ctl_pc_src == NPC_JUMP)
      |=> pc_q[1:0] == 2'b00 &&
          pc_q[XLEN-1 -: PC_HI_W] == $past(pc_q[XLEN-1 -: PC_HI_W]));

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        ctl_addr_alu, ctl_ir_we, ctl_pc_we, ctl_pc_we_zero, ctl_opa_reg;
   logic [1:0]  ctl_opb_sel, ctl_alu_mode, ctl_pc_src;
   logic        ctl_dst_rd, ctl_wb_mdr, ctl_rf_we;
   logic [5:0]  opcode;
   logic        alu_zero;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [31:0] shadow [32];
   logic [31:0] pc_exp;

   always #(CLK_NS/2) clk = ~clk;

   mc_datapath u_mc_datapath (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ctl_addr_alu(ctl_addr_alu), .ctl_ir_we(ctl_ir_we),
      .ctl_pc_we(ctl_pc_we), .ctl_pc_we_zero(ctl_pc_we_zero),
      .ctl_opa_reg(ctl_opa_reg), .ctl_opb_sel(ctl_opb_sel),
      .ctl_alu_mode(ctl_alu_mode), .ctl_pc_src(ctl_pc_src),
      .ctl_dst_rd(ctl_dst_rd), .ctl_wb_mdr(ctl_wb_mdr), .ctl_rf_we(ctl_rf_we),
      .opcode(opcode), .alu_zero(alu_zero)
   );

   function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fc);
      return {6'h00, rs, rt, rd, 5'd0, fc};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                         input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] r_expect(input logic [5:0] fc, input logic [31:0] a, b);
      case (fc)
         6'h22:   return a - b;
         6'h24:   return a & b;
         6'h25:   return a | b;
         6'h2A:   return {31'd0, $signed(a) < $signed(b)};
         default: return a + b;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic ctl_idle();
      ctl_addr_alu = 0; ctl_ir_we = 0; ctl_pc_we = 0; ctl_pc_we_zero = 0;
      ctl_opa_reg = 0; ctl_opb_sel = 2'b00; ctl_alu_mode = 2'b00;
      ctl_pc_src = 2'b00; ctl_dst_rd = 0; ctl_wb_mdr = 0; ctl_rf_we = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      ctl_idle();
   endtask

   // fetch plus decode; leaves pc_exp advanced by four
   task automatic fetch_decode(input logic [31:0] instr);
      ctl_idle();
      ctl_ir_we = 1; ctl_pc_we = 1; ctl_opb_sel = 2'b01;
      mem_rdata = instr;
      #1;
      check("R1 fetch address is PC", mem_addr, pc_exp);
      tick();
      pc_exp = pc_exp + 4;
      ctl_opb_sel = 2'b11;
      mem_rdata = ~instr;           // IR must ignore this (R2)
      #1;
      check("R2 opcode field", {26'd0, opcode}, {26'd0, instr[31:26]});
      tick();
      check("R2 IR held without load", {26'd0, opcode}, {26'd0, instr[31:26]});
   endtask

   task automatic do_rtype(input logic [4:0] rs, rt, rd, input logic [5:0] fc);
      fetch_decode(enc_r(rs, rt, rd, fc));
      ctl_opa_reg = 1; ctl_alu_mode = 2'b10;
      tick();
      ctl_dst_rd = 1; ctl_rf_we = 1;
      tick();
      if (rd != 0) shadow[rd] = r_expect(fc, shadow[rs], shadow[rt]);
   endtask

   task automatic do_load(input logic [4:0] rs, rt, input logic [15:0] imm,
                          input logic [31:0] data);
      fetch_decode(enc_i(6'h23, rs, rt, imm));
      ctl_opa_reg = 1; ctl_opb_sel = 2'b10;
      tick();
      ctl_addr_alu = 1; mem_rdata = data;
      #1;
      check("R4 load address base+sext", mem_addr, shadow[rs] + sext(imm));
      tick();
      mem_rdata = 32'hDEAD_0000;    // MDR already captured (R10)
      ctl_wb_mdr = 1; ctl_rf_we = 1;
      tick();
      if (rt != 0) shadow[rt] = data;
   endtask

   task automatic do_store(input logic [4:0] rs, rt, input logic [15:0] imm, input string tag);
      fetch_decode(enc_i(6'h2B, rs, rt, imm));
      ctl_opa_reg = 1; ctl_opb_sel = 2'b10;
      tick();
      ctl_addr_alu = 1;
      #1;
      check({tag, " R1 store address"}, mem_addr, shadow[rs] + sext(imm));
      check({tag, " R3 store data is B"}, mem_wdata, shadow[rt]);
      tick();
   endtask

   task automatic do_branch(input logic [4:0] rs, rt, input logic [15:0] imm);
      logic taken;
      fetch_decode(enc_i(6'h04, rs, rt, imm));
      taken = (shadow[rs] == shadow[rt]);
      ctl_opa_reg = 1; ctl_alu_mode = 2'b01; ctl_pc_src = 2'b01; ctl_pc_we_zero = 1;
      #1;
      check("R6 zero flag on compare", {31'd0, alu_zero}, {31'd0, taken});
      tick();
      if (taken) pc_exp = pc_exp + (sext(imm) << 2);
   endtask

   task automatic do_jump(input logic [25:0] idx);
      fetch_decode({6'h02, idx});
      ctl_pc_we = 1; ctl_pc_src = 2'b10;
      tick();
      pc_exp = {pc_exp[31:28], idx, 2'b00};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5EED));
      ctl_idle();
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      pc_exp = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset PC is zero", mem_addr, 32'd0);
      check("R2 reset opcode", {26'd0, opcode}, 32'd0);
      rst_n = 1'b1;
      #1;

      // directed loads, including a negative offset (R4, R10, R9)
      do_load(5'd0, 5'd1, 16'h0010, 32'h0000_0007);
      do_load(5'd0, 5'd2, 16'hFFF0, 32'hFFFF_FFF9);
      do_load(5'd1, 5'd3, 16'h0004, 32'h0000_0007);
      do_store(5'd0, 5'd1, 16'h0020, "R10 loaded value via MDR");
      do_store(5'd2, 5'd2, 16'h8000, "R4 negative offset");

      // each function code, and an unlisted one that adds (R5)
      do_rtype(5'd1, 5'd2, 5'd4, 6'h20); do_store(5'd0, 5'd4, 16'h0, "R5 add");
      do_rtype(5'd1, 5'd2, 5'd5, 6'h22); do_store(5'd0, 5'd5, 16'h0, "R5 sub");
      do_rtype(5'd1, 5'd2, 5'd6, 6'h24); do_store(5'd0, 5'd6, 16'h0, "R5 and");
      do_rtype(5'd1, 5'd2, 5'd7, 6'h25); do_store(5'd0, 5'd7, 16'h0, "R5 or");
      do_rtype(5'd2, 5'd1, 5'd8, 6'h2A); do_store(5'd0, 5'd8, 16'h0, "R5 slt signed");
      do_rtype(5'd1, 5'd2, 5'd9, 6'h2A); do_store(5'd0, 5'd9, 16'h0, "R5 slt false");
      do_rtype(5'd1, 5'd2, 5'd10, 6'h07); do_store(5'd0, 5'd10, 16'h0, "R5 unknown code adds");

      // writes aimed at register 0 (R9)
      do_rtype(5'd1, 5'd1, 5'd0, 6'h20); do_store(5'd0, 5'd0, 16'h0, "R9 r0 after rtype");
      do_load(5'd0, 5'd0, 16'h0, 32'hFFFF_FFFF); do_store(5'd0, 5'd0, 16'h0, "R9 r0 after load");

      // branches: taken forward, not taken, taken backward (R6, R7, R8)
      do_branch(5'd1, 5'd3, 16'h0008);
      do_branch(5'd1, 5'd2, 16'h0008);
      do_branch(5'd0, 5'd0, 16'hFFFC);
      do_jump(26'h0000_040);
      do_jump(26'h3FF_FFFF);
      do_store(5'd0, 5'd1, 16'h0, "R7 after jump");

      // constrained random mix
      for (int k = 0; k < 60; k++) begin
         logic [4:0] s, t, d;
         logic [5:0] fcs [5];
         fcs[0] = 6'h20; fcs[1] = 6'h22; fcs[2] = 6'h24; fcs[3] = 6'h25; fcs[4] = 6'h2A;
         s = 5'($urandom_range(0, 15));
         t = 5'($urandom_range(0, 15));
         d = 5'($urandom_range(1, 15));
         case ($urandom_range(0, 3))
            0: do_load(5'd0, d, 16'($urandom_range(0, 255) * 4), $urandom());
            1: do_rtype(s, t, d, fcs[$urandom_range(0, 4)]);
            2: do_branch(s, t, 16'($urandom_range(0, 7)));
            default: do_store(s, t, 16'($urandom()), "R3 random store");
         endcase
      end
      for (int r = 1; r < 16; r++) do_store(5'd0, 5'(r), 16'h0, "R9 final register sweep");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule